// File: doc/BRIEF.md
# Debounced Diagnostic Mode Selector

This block turns three slow, asynchronous mode-select pins and an active-low power-on reset pin into a clean, decoded operating mode for an optical modem core. Each pin is brought into the crystal clock domain through a synchronizer. A new pin code is accepted only after it has held still for a fixed settle window of crystal cycles. Any further movement on the pins inside that window starts the window again. The power-on reset pin bypasses the settle window and forces the reset mode as soon as it has passed the synchronizer.

The accepted code is decoded into a one-hot lock-type vector (drift, random, active), a slave flag and three loopback flags. The decode also produces LED and transmit-clock drive enables and a fast-cycle request for active lock. A legacy single-channel strap decides whether loopback modes may be used. Without it, a loopback code falls back to its plain lock type. A loopback request arriving from the far end is honoured only when no near-end loopback is active. The circuits that acquire lock are outside this block. They consume `lock_sel` and `fast_cycle` and report back through `link_locked`.

Top module: `dms_mode_sel`

## Requirements
- R1: After `rst_n` is released, the accepted code is 001 (reset): `in_reset`=1, and `led_en`, `lock_sel`, `slave_en`, all loop flags, `txclk_drive` and `fast_cycle` are 0.
- R2: A new code on `dm_pin` (bit 2 = DM3, bit 0 = DM1) replaces the accepted code exactly `SETTLE_CYC` cycles after the change is seen past the synchronizer. With pins driven between edges and the default two-stage synchronizer, the old decode still holds after `SETTLE_CYC`+2 rising edges, and the new decode holds after `SETTLE_CYC`+3.
- R3: A pin change during the settle window restarts the full window from that change. The earlier, interrupted code is never accepted.
- R4: Code 000 and code 110 select drift lock (`lock_sel`=001). Code 011 selects random lock (`lock_sel`=010). Code 111 selects active lock (`lock_sel`=100). Code 101 selects active lock with `slave_en`=1.
- R5: While the synchronized `por_pin_n` is low, the outputs take the reset state of R1 whatever the accepted code is. Two rising edges after `por_pin_n` is released, the decode of the accepted code returns without a new settle window.
- R6: The accepted code 001 gives the reset state of R1.
- R7: With `legacy_mode`=1, code 010 gives remote loopback (`loop_remote`=1) with active lock, and code 100 gives local loopback (`loop_local`=1) with drift lock.
- R8: With `legacy_mode`=0, codes 010 and 100 give active lock and drift lock respectively, with every loop flag at 0. `loop_serve` is also 0.
- R9: `loop_serve` equals `peer_loop_req` only in legacy mode, outside reset, and while neither `loop_local` nor `loop_remote` is set. Local loopback therefore takes priority over a far-end request, and at most one loop flag is ever set.
- R10: Outside reset, `txclk_drive` is 1 when `slave_en`=1, whatever `clk_ext_sel` is. Otherwise `txclk_drive` is the inverse of `clk_ext_sel`.
- R11: `fast_cycle` is 1 exactly when active lock is selected and `link_locked`=0.
- R12: Outside reset, `led_en`=1 and exactly one bit of `lock_sel` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dm_pin | input | 3 | Asynchronous mode-select pins, bit 2 = DM3 |
| por_pin_n | input | 1 | Asynchronous active-low power-on reset pin |
| legacy_mode | input | 1 | Static strap that enables the legacy single-channel mode |
| clk_ext_sel | input | 1 | Static strap: 1 means the transmit clock is supplied externally |
| peer_loop_req | input | 1 | Far-end loopback request, synchronous to clk |
| link_locked | input | 1 | Lock indication from the lock logic, synchronous to clk |
| in_reset | output | 1 | Reset mode active |
| led_en | output | 1 | LED driver enable |
| lock_sel | output | 3 | One-hot lock type: bit 0 drift, bit 1 random, bit 2 active |
| slave_en | output | 1 | Clock-slave mode |
| loop_local | output | 1 | Near-end local loopback |
| loop_remote | output | 1 | Near-end remote loopback request |
| loop_serve | output | 1 | Loop back received data for the far end |
| txclk_drive | output | 1 | Drive the transmit clock pin as an output |
| fast_cycle | output | 1 | Shorten the machine cycle to acquire lock |

## Verification
A wrong count or a missed window restart in the settle counter shows up at the ports as a decode that switches one or more cycles early or late. The bench therefore checks both the last edge on which the old decode must still hold and the first edge on which the new one must appear. A stale or corrupted accepted code appears as a wrong `lock_sel` or loop flag as soon as the combinational decode settles after the capture edge. A broken reset override shows as `led_en` left high two edges after `por_pin_n` falls. A broken loopback priority shows as `loop_serve` rising alongside a near-end loopback in the same cycle as the request.

// File: rtl/dms_pkg.sv
package dms_pkg;

   localparam int CODE_W = 3;

   // pin codes, bit 2 = DM3
   localparam logic [CODE_W-1:0] C_DRIFT  = 3'b000;
   localparam logic [CODE_W-1:0] C_RESET  = 3'b001;
   localparam logic [CODE_W-1:0] C_RLOOP  = 3'b010;
   localparam logic [CODE_W-1:0] C_RANDOM = 3'b011;
   localparam logic [CODE_W-1:0] C_LLOOP  = 3'b100;
   localparam logic [CODE_W-1:0] C_SLAVE  = 3'b101;
   localparam logic [CODE_W-1:0] C_SPARE  = 3'b110;
   localparam logic [CODE_W-1:0] C_ACTIVE = 3'b111;

   localparam int LOCK_N  = 3;
   localparam int LK_DRIFT  = 0;
   localparam int LK_RANDOM = 1;
   localparam int LK_ACTIVE = 2;

   typedef struct packed {
      logic              hold;
      logic              led;
      logic [LOCK_N-1:0] lock;
      logic              slave;
      logic              lb_local;
      logic              lb_remote;
      logic              lb_serve;
      logic              txdrv;
      logic              fast;
   } mode_t;

   localparam mode_t MODE_HELD = '{hold: 1'b1, led: 1'b0, lock: '0, slave: 1'b0,
                                   lb_local: 1'b0, lb_remote: 1'b0, lb_serve: 1'b0,
                                   txdrv: 1'b0, fast: 1'b0};

endpackage

// File: rtl/dms_sync.sv
module dms_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dms_settle.sv
module dms_settle #(
   parameter int               WIDTH      = 3,
   parameter int               SETTLE_CYC = 1536,
   parameter logic [WIDTH-1:0] RST_VAL    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] code_o,
   output logic             pend_o
);

   localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] code_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             moved;
   logic             expire;

   assign moved  = (d_i != prev_q);
   assign expire = pend_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
         code_q <= RST_VAL;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= d_i;
         if (moved) begin
            // any movement starts the window again
            pend_q <= 1'b1;
            cnt_q  <= LOAD;
         end else if (expire) begin
            pend_q <= 1'b0;
            code_q <= d_i;
         end else if (pend_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign code_o = code_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/dms_decode.sv
module dms_decode
   import dms_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   input  logic              por_ok_i,
   input  logic              legacy_i,
   input  logic              peer_req_i,
   input  logic              clk_ext_i,
   input  logic              locked_i,
   output mode_t             mode_o
);

   logic [LOCK_N-1:0] lock_v;
   logic              slave_v;
   logic              want_local;
   logic              want_remote;
   logic              held;

   always_comb begin
      lock_v      = '0;
      slave_v     = 1'b0;
      want_local  = 1'b0;
      want_remote = 1'b0;
      unique case (code_i)
         C_RANDOM: lock_v[LK_RANDOM] = 1'b1;
         C_ACTIVE: lock_v[LK_ACTIVE] = 1'b1;
         C_SLAVE: begin
            lock_v[LK_ACTIVE] = 1'b1;
            slave_v           = 1'b1;
         end
         C_RLOOP: begin
            lock_v[LK_ACTIVE] = 1'b1;
            want_remote       = 1'b1;
         end
         C_LLOOP: begin
            lock_v[LK_DRIFT] = 1'b1;
            want_local       = 1'b1;
         end
         C_RESET: lock_v = '0;
         C_DRIFT, C_SPARE: lock_v[LK_DRIFT] = 1'b1;
         default: lock_v[LK_DRIFT] = 1'b1;
      endcase
   end

   assign held = !por_ok_i || (code_i == C_RESET);

   always_comb begin
      if (held) begin
         mode_o = MODE_HELD;
      end else begin
         mode_o.hold      = 1'b0;
         mode_o.led       = 1'b1;
         mode_o.lock      = lock_v;
         mode_o.slave     = slave_v;
         mode_o.lb_local  = legacy_i && want_local;
         mode_o.lb_remote = legacy_i && want_remote && !want_local;
         mode_o.lb_serve  = legacy_i && peer_req_i && !want_local && !want_remote;
         mode_o.txdrv     = slave_v || !clk_ext_i;
         mode_o.fast      = lock_v[LK_ACTIVE] && !locked_i;
      end
   end

endmodule

// File: rtl/dms_mode_sel.sv
module dms_mode_sel
   import dms_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 1536,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        dm_pin,
   input  logic              por_pin_n,
   input  logic              legacy_mode,
   input  logic              clk_ext_sel,
   input  logic              peer_loop_req,
   input  logic              link_locked,
   output logic              in_reset,
   output logic              led_en,
   output logic [2:0]        lock_sel,
   output logic              slave_en,
   output logic              loop_local,
   output logic              loop_remote,
   output logic              loop_serve,
   output logic              txclk_drive,
   output logic              fast_cycle
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dms_mode_sel: SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("dms_mode_sel: SETTLE_CYC must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] pins_s;
   logic              por_ok;
   logic [CODE_W-1:0] acc_code;
   logic              settle_pend;
   mode_t             mode_d;
   mode_t             mode_q;

   dms_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL(C_RESET)) u_pin_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (dm_pin),
      .sync_o  (pins_s)
   );

   dms_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (por_pin_n),
      .sync_o  (por_ok)
   );

   dms_settle #(.WIDTH(CODE_W), .SETTLE_CYC(SETTLE_CYC), .RST_VAL(C_RESET)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pins_s),
      .code_o (acc_code),
      .pend_o (settle_pend)
   );

   dms_decode u_decode (
      .code_i     (acc_code),
      .por_ok_i   (por_ok),
      .legacy_i   (legacy_mode),
      .peer_req_i (peer_loop_req),
      .clk_ext_i  (clk_ext_sel),
      .locked_i   (link_locked),
      .mode_o     (mode_d)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mode_q <= MODE_HELD;
            else        mode_q <= mode_d;
         end
      end else begin : g_comb_out
         assign mode_q = mode_d;
      end
   endgenerate

   assign in_reset    = mode_q.hold;
   assign led_en      = mode_q.led;
   assign lock_sel    = mode_q.lock;
   assign slave_en    = mode_q.slave;
   assign loop_local  = mode_q.lb_local;
   assign loop_remote = mode_q.lb_remote;
   assign loop_serve  = mode_q.lb_serve;
   assign txclk_drive = mode_q.txdrv;
   assign fast_cycle  = mode_q.fast;

endmodule

// File: rtl/dms_mode_sel_chk.sv
module dms_mode_sel_chk #(
   parameter bit REG_OUT = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       por_ok,
   input logic       settle_pend,
   input logic [2:0] acc_code,
   input logic       legacy_mode,
   input logic       in_reset,
   input logic       led_en,
   input logic [2:0] lock_sel,
   input logic       slave_en,
   input logic       loop_local,
   input logic       loop_remote,
   input logic       loop_serve,
   input logic       txclk_drive,
   input logic       fast_cycle
);

   // R1 / R6: reset state carries no lock, LED off
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      in_reset |-> (lock_sel == 3'b000) && !led_en && !txclk_drive && !fast_cycle);

   // R12: exactly one lock type outside reset
   a_r12_lock_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      !in_reset |-> ($countones(lock_sel) == 1) && led_en);

   // R2: the accepted code moves only when the settle window closes
   a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_code) |-> $fell(settle_pend));

   // R9: loop flags mutually exclusive
   a_r9_loop_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loop_local, loop_remote, loop_serve}));

   // R10: slave always drives the transmit clock
   a_r10_slave_drive: assert property (@(posedge clk) disable iff (!rst_n)
      slave_en |-> txclk_drive);

   // R11: fast cycle only with active lock
   a_r11_fast_active: assert property (@(posedge clk) disable iff (!rst_n)
      fast_cycle |-> lock_sel[2]);

   generate
      if (REG_OUT) begin : g_reg
         // R5
         a_r5_por_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !por_ok |=> in_reset);
         // R8
         a_r8_no_loop: assert property (@(posedge clk) disable iff (!rst_n)
            !legacy_mode && $past(!legacy_mode) |-> !(loop_local || loop_remote || loop_serve));
      end else begin : g_comb
         // R5
         a_r5_por_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !por_ok |-> in_reset);
         // R8
         a_r8_no_loop: assert property (@(posedge clk) disable iff (!rst_n)
            !legacy_mode |-> !(loop_local || loop_remote || loop_serve));
      end
   endgenerate

endmodule

bind dms_mode_sel dms_mode_sel_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .por_ok      (por_ok),
   .settle_pend (settle_pend),
   .acc_code    (acc_code),
   .legacy_mode (legacy_mode),
   .in_reset    (in_reset),
   .led_en      (led_en),
   .lock_sel    (lock_sel),
   .slave_en    (slave_en),
   .loop_local  (loop_local),
   .loop_remote (loop_remote),
   .loop_serve  (loop_serve),
   .txclk_drive (txclk_drive),
   .fast_cycle  (fast_cycle)
);

// File: tb/dms_mode_sel_bench.sv
module dms_mode_sel_bench;

   localparam int SETTLE = 1536;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] dm_pin = 3'b001;
   logic       por_pin_n = 1'b1;
   logic       legacy_mode = 1'b0;
   logic       clk_ext_sel = 1'b0;
   logic       peer_loop_req = 1'b0;
   logic       link_locked = 1'b1;

   logic       in_reset, led_en, slave_en, loop_local, loop_remote, loop_serve;
   logic       txclk_drive, fast_cycle;
   logic [2:0] lock_sel;

   int n_chk  = 0;
   int n_fail = 0;
   logic [2:0] cur_code = 3'b001;

   always #2 clk = ~clk;

   dms_mode_sel #(.SETTLE_CYC(SETTLE)) u_dms_mode_sel (
      .clk(clk), .rst_n(rst_n), .dm_pin(dm_pin), .por_pin_n(por_pin_n),
      .legacy_mode(legacy_mode), .clk_ext_sel(clk_ext_sel),
      .peer_loop_req(peer_loop_req), .link_locked(link_locked),
      .in_reset(in_reset), .led_en(led_en), .lock_sel(lock_sel), .slave_en(slave_en),
      .loop_local(loop_local), .loop_remote(loop_remote), .loop_serve(loop_serve),
      .txclk_drive(txclk_drive), .fast_cycle(fast_cycle)
   );

   // {in_reset, led_en, lock_sel[2:0], slave, local, remote, serve, txdrv, fast}
   function automatic logic [10:0] model(input logic [2:0] c, input logic por);
      logic [2:0] lk;
      logic sl, ll, lr, ls;
      lk = 3'b001; sl = 1'b0; ll = 1'b0; lr = 1'b0;
      if (!por || c == 3'b001) return 11'b100_0000_0000;
      case (c)
         3'b011: lk = 3'b010;
         3'b111: lk = 3'b100;
         3'b101: begin lk = 3'b100; sl = 1'b1; end
         3'b010: begin lk = 3'b100; lr = legacy_mode; end
         3'b100: begin lk = 3'b001; ll = legacy_mode; end
         default: lk = 3'b001;
      endcase
      ls = legacy_mode && peer_loop_req && !ll && !lr;
      return {1'b0, 1'b1, lk, sl, ll, lr, ls, sl | !clk_ext_sel, lk[2] & !link_locked};
   endfunction

   function automatic logic [10:0] obs();
      return {in_reset, led_en, lock_sel, slave_en, loop_local, loop_remote,
              loop_serve, txclk_drive, fast_cycle};
   endfunction

   task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // drive a new code and check both sides of the capture edge (R2)
   task automatic apply_code(input logic [2:0] c, input string req);
      logic [2:0] old;
      old = cur_code;
      @(negedge clk) dm_pin = c;
      repeat (SETTLE + 2) @(posedge clk);
      @(negedge clk);
      check({req, " R2 before capture"}, obs(), model(old, 1'b1));
      @(posedge clk);
      @(negedge clk);
      check({req, " R2 after capture"}, obs(), model(c, 1'b1));
      cur_code = c;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 reset state", obs(), 11'b100_0000_0000);
   endtask

   task automatic t_settle();
      apply_code(3'b111, "R2 reset->active");
   endtask

   task automatic t_codes();
      link_locked = 1'b1;
      apply_code(3'b000, "R4 drift");
      apply_code(3'b011, "R4 random");
      apply_code(3'b101, "R4 slave");
      apply_code(3'b110, "R4 spare as drift");
      apply_code(3'b111, "R4 active");
      apply_code(3'b001, "R6 reset code");
   endtask

   task automatic t_restart();
      @(negedge clk) dm_pin = 3'b011;
      repeat (SETTLE / 2) @(posedge clk);
      @(negedge clk) dm_pin = 3'b000;
      repeat (SETTLE + 2) @(posedge clk);
      @(negedge clk);
      check("R3 interrupted code not taken", obs(), model(3'b001, 1'b1));
      @(posedge clk);
      @(negedge clk);
      check("R3 final code after restart", obs(), model(3'b000, 1'b1));
      cur_code = 3'b000;
   endtask

   task automatic t_legacy();
      legacy_mode = 1'b1;
      apply_code(3'b010, "R7 remote loop");
      @(negedge clk);
      check("R7 remote flag", {10'b0, loop_remote}, 11'd1);
      apply_code(3'b100, "R7 local loop");
      @(negedge clk);
      check("R7 local flag", {10'b0, loop_local}, 11'd1);
   endtask

   task automatic t_nonlegacy();
      @(negedge clk) legacy_mode = 1'b0;
      #1;
      check("R8 local code without legacy", obs(), 11'b010_0100_0010);
      apply_code(3'b010, "R8 remote code without legacy");
      check("R8 remote code is plain active", obs(), 11'b011_0000_0010);
   endtask

   task automatic t_peer();
      legacy_mode = 1'b1;
      apply_code(3'b100, "R9 setup local");
      @(negedge clk) peer_loop_req = 1'b1;
      #1;
      check("R9 local beats peer", {10'b0, loop_serve}, 11'd0);
      apply_code(3'b000, "R9 drift with peer");
      check("R9 peer served", {10'b0, loop_serve}, 11'd1);
      @(negedge clk) legacy_mode = 1'b0;
      #1;
      check("R9 no serve outside legacy", {10'b0, loop_serve}, 11'd0);
      @(negedge clk) peer_loop_req = 1'b0;
   endtask

   task automatic t_por();
      apply_code(3'b111, "R5 setup active");
      @(negedge clk) por_pin_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R5 one edge after por low", obs(), model(3'b111, 1'b1));
      @(posedge clk);
      @(negedge clk);
      check("R5 por forces reset", obs(), model(3'b111, 1'b0));
      por_pin_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R5 release restores code", obs(), model(3'b111, 1'b1));
   endtask

   task automatic t_slave();
      @(negedge clk) clk_ext_sel = 1'b1;
      #1;
      check("R10 external clock not driven", {10'b0, txclk_drive}, 11'd0);
      apply_code(3'b101, "R10 slave");
      check("R10 slave overrides", {10'b0, txclk_drive}, 11'd1);
      @(negedge clk) clk_ext_sel = 1'b0;
   endtask

   task automatic t_fast();
      apply_code(3'b111, "R11 setup active");
      @(negedge clk) link_locked = 1'b0;
      #1;
      check("R11 fast while unlocked", {10'b0, fast_cycle}, 11'd1);
      @(negedge clk) link_locked = 1'b1;
      #1;
      check("R11 fast off when locked", {10'b0, fast_cycle}, 11'd0);
      link_locked = 1'b0;
      apply_code(3'b011, "R11 random unlocked");
      check("R11 no fast for random", {10'b0, fast_cycle}, 11'd0);
      check("R12 one lock bit", {8'b0, lock_sel}, 11'b010);
      link_locked = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_settle();
      t_codes();
      t_restart();
      t_legacy();
      t_nonlegacy();
      t_peer();
      t_por();
      t_slave();
      t_fast();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule